// File: doc/BRIEF.md
# Memory Region Access Guard

This block sits on the path between one bus master and memory. It judges every access against a small table of programmable address regions and either lets the access through or blocks it. Each access carries an address and three flags: write, instruction fetch and privileged. Each region has a base, a power-of-two size, eight subregion disable bits, separate permissions for privileged and user mode, an execute-never bit and an enable bit. Where regions overlap, the one with the highest index decides.

The grant or deny answer is combinational, so it is available in the same cycle as the request. The first denied access latches a fault, and this state is terminal. The block stores the offending address and a cause word, and from then on it refuses every request until a hardware reset. A plain write port loads region words and a global enable. After reset the table holds a six-region map: a 4 GB background with no data access, and smaller regions layered over it that do grant access.

Top module: `mem_region_guard`

## Requirements
- R1: After reset, `fault`=0, `fault_addr`=0, `fault_status`=0, the global enable is 1 and the regions are (index: base, log2 size, privileged/user permission, execute-never): 0: 0x00000000, 32, none/none, 0; 1: 0x10000000, 23, read-only/read-only, 0; 2: 0x14000000, 18, read-only/none, 1; 3: 0x28000000, 20, read/write both, 0; 4: 0x40000000, 26, read/write both, 1; 5: 0xE0000000, 29, read/write both, 1. In all of them every subregion is on. Regions 6 and 7 are disabled.
- R2: A write with `cfg_we`=1 takes effect from the next cycle. When `cfg_addr[4]`=1 the write is the control word, and `cfg_wdata[0]` is the global enable. Otherwise `cfg_addr[3:1]` selects the region. With `cfg_addr[0]`=0 the write sets the base to `cfg_wdata[31:8]`. With `cfg_addr[0]`=1 it sets the attributes: [5:0] log2 size, [15:8] subregion disables, [17:16] privileged permission, [19:18] user permission, [20] execute-never, [31] region enable.
- R3: A region covers 2^s bytes, where s is the log2 size field. Values below 8 act as 8, and values of 32 or more cover the whole space. The region starts at the base with its bits below s cleared.
- R4: A region is split into eight equal subregions, numbered by offset/(size/8). When disable bit k is set, subregion k does not match.
- R5: Among the enabled regions that match, the highest index decides the permissions. An address that no region matches is denied.
- R6: Permission encoding: 00 means no access, 01 read-only, 1x read/write. Privileged accesses use the privileged field and user accesses use the user field. A read needs a nonzero permission, and a write needs bit 1 set.
- R7: An instruction fetch is granted only if the deciding region gives read permission in the current mode and its execute-never bit is 0. The write flag is ignored for fetches.
- R8: While `acc_req`=1, exactly one of `acc_gnt` and `acc_deny` is 1, in the same cycle. While `acc_req`=0, both are 0.
- R9: While the global enable is 0 and no fault is latched, every request is granted and no fault is recorded.
- R10: On the first denied request, `fault` rises on the next clock edge and `fault_addr` takes the request address. `fault_status` takes the value {1, not fetch, fetch}: bit 2 means the address is valid, bit 1 marks a data violation and bit 0 a fetch violation.
- R11: Once `fault` is set, it stays set, and `fault_addr` and `fault_status` stay unchanged, until reset. Every later request is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| acc_req | input | 1 | Access request |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | 1 = instruction fetch |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| acc_gnt | output | 1 | Access granted |
| acc_deny | output | 1 | Access denied |
| fault | output | 1 | Sticky fault flag |
| fault_addr | output | 32 | Address of the first denied access |
| fault_status | output | 3 | Cause of the first fault |

## Verification
A wrong region entry, a bad priority choice or a mis-decoded subregion changes the grant or deny answer in the same cycle as the request. This shows up at once on addresses near region edges and subregion boundaries. A capture that is wrong, or that is lost later, shows up one cycle after the denial in `fault_addr` or `fault_status`, and again on the next denied request, which must leave both unchanged. Once any access has been wrongly granted or denied, the bench model and the design disagree from that point until the next reset.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

  typedef struct packed {
    logic        en;
    logic        xn;
    logic [1:0]  up;
    logic [1:0]  pp;
    logic [7:0]  srd;
    logic [5:0]  szl;
    logic [23:0] base;
  } region_t;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_RW   = 2'b10;

  function automatic region_t mk_region(input logic [23:0] b, input logic [5:0] s,
                                        input logic [1:0] p, input logic [1:0] u,
                                        input logic x);
    region_t r;
    r.en   = 1'b1;
    r.xn   = x;
    r.up   = u;
    r.pp   = p;
    r.srd  = 8'h00;
    r.szl  = s;
    r.base = b;
    return r;
  endfunction

  // power-on map
  function automatic region_t boot_region(input int idx);
    case (idx)
      0:       return mk_region(24'h000000, 6'd32, PERM_NONE, PERM_NONE, 1'b0);
      1:       return mk_region(24'h100000, 6'd23, PERM_RO,   PERM_RO,   1'b0);
      2:       return mk_region(24'h140000, 6'd18, PERM_RO,   PERM_NONE, 1'b1);
      3:       return mk_region(24'h280000, 6'd20, PERM_RW,   PERM_RW,   1'b0);
      4:       return mk_region(24'h400000, 6'd26, PERM_RW,   PERM_RW,   1'b1);
      5:       return mk_region(24'hE00000, 6'd29, PERM_RW,   PERM_RW,   1'b1);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/mrg_cfg_regs.sv
module mrg_cfg_regs
  import mrg_pkg::*;
#(
  parameter int NREG = 8,
  parameter int IDXW = 3,
  parameter int CAW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output region_t        regs_o [NREG],
  output logic           glb_en_o
);

  region_t regs_q [NREG];
  region_t regs_d [NREG];
  logic    en_q, en_d;

  always_comb begin
    regs_d = regs_q;
    en_d   = en_q;
    if (cfg_addr[CAW-1]) begin
      en_d = cfg_wdata[0];
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (cfg_addr[CAW-2:1] == IDXW'(i)) begin
          if (cfg_addr[0]) begin
            regs_d[i].szl = cfg_wdata[5:0];
            regs_d[i].srd = cfg_wdata[15:8];
            regs_d[i].pp  = cfg_wdata[17:16];
            regs_d[i].up  = cfg_wdata[19:18];
            regs_d[i].xn  = cfg_wdata[20];
            regs_d[i].en  = cfg_wdata[31];
          end else begin
            regs_d[i].base = cfg_wdata[31:8];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= boot_region(i);
      en_q <= 1'b1;
    end else if (cfg_we) begin
      regs_q <= regs_d;
      en_q   <= en_d;
    end
  end

  assign regs_o   = regs_q;
  assign glb_en_o = en_q;

endmodule

// File: rtl/mrg_region_match.sv
module mrg_region_match
  import mrg_pkg::*;
(
  input  region_t     rgn,
  input  logic [31:0] addr,
  output logic        hit
);

  logic [5:0]  shamt;
  logic [31:0] lowmask;
  logic        in_rng;
  logic [2:0]  sub;

  always_comb begin
    shamt   = (rgn.szl < 6'd8) ? 6'd8 : rgn.szl;
    lowmask = 32'hFFFF_FFFF;
    if (shamt >= 6'd32) begin
      in_rng = 1'b1;
      sub    = addr[31:29];
    end else begin
      lowmask = (32'h1 << shamt) - 32'h1;
      in_rng  = ((addr ^ {rgn.base, 8'h00}) & ~lowmask) == 32'h0;
      sub     = 3'((addr >> (shamt - 6'd3)) & 32'h7);
    end
    hit = rgn.en & in_rng & ~rgn.srd[sub];
  end

endmodule

// File: rtl/mrg_decide.sv
module mrg_decide
  import mrg_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0] hits,
  input  region_t         regs [NREG],
  input  logic            acc_write,
  input  logic            acc_fetch,
  input  logic            acc_priv,
  output logic            allow
);

  logic       found;
  region_t    sel;
  logic [1:0] perm;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hits[i]) begin
        found = 1'b1;
        sel   = regs[i];
      end
    end
    perm = acc_priv ? sel.pp : sel.up;
    if (!found)         allow = 1'b0;
    else if (acc_fetch) allow = (perm != PERM_NONE) & ~sel.xn;
    else if (acc_write) allow = perm[1];
    else                allow = (perm != PERM_NONE);
  end

endmodule

// File: rtl/mrg_fault_log.sv
module mrg_fault_log (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trip,
  input  logic [31:0] trip_addr,
  input  logic        trip_fetch,
  output logic        fault_o,
  output logic [31:0] addr_o,
  output logic [2:0]  status_o
);

  logic        fault_q, fault_d;
  logic [31:0] addr_q, addr_d;
  logic [2:0]  stat_q, stat_d;
  logic        load;

  assign load = trip & ~fault_q;

  always_comb begin
    fault_d = 1'b1;
    addr_d  = trip_addr;
    stat_d  = {1'b1, ~trip_fetch, trip_fetch};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      addr_q  <= 32'h0;
      stat_q  <= 3'b000;
    end else if (load) begin
      fault_q <= fault_d;
      addr_q  <= addr_d;
      stat_q  <= stat_d;
    end
  end

  assign fault_o  = fault_q;
  assign addr_o   = addr_q;
  assign status_o = stat_q;

endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
  import mrg_pkg::*;
#(
  parameter  int NREG = 8,
  localparam int IDXW = $clog2(NREG),
  localparam int CAW  = IDXW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [31:0]    cfg_wdata,
  input  logic           acc_req,
  input  logic [31:0]    acc_addr,
  input  logic           acc_write,
  input  logic           acc_fetch,
  input  logic           acc_priv,
  output logic           acc_gnt,
  output logic           acc_deny,
  output logic           fault,
  output logic [31:0]    fault_addr,
  output logic [2:0]     fault_status
);

  region_t         regs [NREG];
  logic            glb_en;
  logic [NREG-1:0] hits;
  logic            allow;
  logic            pass;
  logic            trip;

  mrg_cfg_regs #(.NREG(NREG), .IDXW(IDXW), .CAW(CAW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .regs_o   (regs),
    .glb_en_o (glb_en)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_match
    mrg_region_match u_match (
      .rgn (regs[g]),
      .addr(acc_addr),
      .hit (hits[g])
    );
  end

  mrg_decide #(.NREG(NREG)) u_decide (
    .hits     (hits),
    .regs     (regs),
    .acc_write(acc_write),
    .acc_fetch(acc_fetch),
    .acc_priv (acc_priv),
    .allow    (allow)
  );

  assign pass     = ~fault & (~glb_en | allow);
  assign acc_gnt  = acc_req & pass;
  assign acc_deny = acc_req & ~pass;
  assign trip     = acc_req & glb_en & ~allow;

  mrg_fault_log u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip      (trip),
    .trip_addr (acc_addr),
    .trip_fetch(acc_fetch),
    .fault_o   (fault),
    .addr_o    (fault_addr),
    .status_o  (fault_status)
  );

endmodule

// File: rtl/mem_region_guard_chk.sv
module mem_region_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_req,
  input logic [31:0] acc_addr,
  input logic        acc_fetch,
  input logic        acc_gnt,
  input logic        acc_deny,
  input logic        fault,
  input logic [31:0] fault_addr,
  input logic [2:0]  fault_status
);

  // R8
  answer_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> (acc_gnt ^ acc_deny));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> (!acc_gnt && !acc_deny));

  // R10
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_deny && !fault) |=> (fault && fault_addr == $past(acc_addr)
                              && fault_status == {1'b1, !$past(acc_fetch), $past(acc_fetch)}));

  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && $stable(fault_addr) && $stable(fault_status)));

  // R11
  no_grant_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !acc_gnt);

  // R10
  status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_status[2] && $countones(fault_status[1:0]) == 1));

endmodule

bind mem_region_guard mem_region_guard_chk u_chk (.*);

// File: tb/mem_region_guard_bench.sv
module mem_region_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        acc_req;
  logic [31:0] acc_addr;
  logic        acc_write, acc_fetch, acc_priv;
  logic        acc_gnt, acc_deny, fault;
  logic [31:0] fault_addr;
  logic [2:0]  fault_status;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the region table
  logic [31:0] m_base [8];
  logic [5:0]  m_szl  [8];
  logic [7:0]  m_srd  [8];
  logic [1:0]  m_pp   [8];
  logic [1:0]  m_up   [8];
  logic        m_xn   [8];
  logic        m_en   [8];
  logic        m_glb;

  always #10 clk = ~clk;

  mem_region_guard u_mem_region_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_req(acc_req), .acc_addr(acc_addr), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .acc_priv(acc_priv), .acc_gnt(acc_gnt), .acc_deny(acc_deny), .fault(fault),
    .fault_addr(fault_addr), .fault_status(fault_status)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_model(input int i, input logic [31:0] b, input logic [5:0] s,
                           input logic [1:0] p, input logic [1:0] u, input logic x, input logic e);
    m_base[i] = b; m_szl[i] = s; m_srd[i] = 8'h00; m_pp[i] = p; m_up[i] = u; m_xn[i] = x; m_en[i] = e;
  endtask

  // R1 reset map, written from the requirement
  task automatic model_reset();
    set_model(0, 32'h0000_0000, 6'd32, 2'b00, 2'b00, 1'b0, 1'b1);
    set_model(1, 32'h1000_0000, 6'd23, 2'b01, 2'b01, 1'b0, 1'b1);
    set_model(2, 32'h1400_0000, 6'd18, 2'b01, 2'b00, 1'b1, 1'b1);
    set_model(3, 32'h2800_0000, 6'd20, 2'b10, 2'b10, 1'b0, 1'b1);
    set_model(4, 32'h4000_0000, 6'd26, 2'b10, 2'b10, 1'b1, 1'b1);
    set_model(5, 32'hE000_0000, 6'd29, 2'b10, 2'b10, 1'b1, 1'b1);
    set_model(6, 32'h0, 6'd0, 2'b00, 2'b00, 1'b0, 1'b0);
    set_model(7, 32'h0, 6'd0, 2'b00, 2'b00, 1'b0, 1'b0);
    m_glb = 1'b1;
  endtask

  function automatic logic exp_pass(input logic [31:0] a, input logic w, input logic f, input logic p);
    logic found;
    int   sel;
    logic [1:0] perm;
    found = 1'b0;
    sel = 0;
    if (!m_glb) return 1'b1;
    for (int i = 0; i < 8; i++) begin
      int eff;
      logic [63:0] sz, lo, off;
      eff = (m_szl[i] < 8) ? 8 : ((m_szl[i] >= 32) ? 32 : int'(m_szl[i]));
      sz  = 64'h1 << eff;
      lo  = {32'h0, m_base[i]} & ~(sz - 64'h1);
      if (m_en[i] && {32'h0, a} >= lo && {32'h0, a} < lo + sz) begin
        off = ({32'h0, a} - lo) / (sz >> 3);
        if (!m_srd[i][off[2:0]]) begin
          found = 1'b1;
          sel = i;
        end
      end
    end
    if (!found) return 1'b0;
    perm = p ? m_pp[sel] : m_up[sel];
    if (f) return (perm != 2'b00) && !m_xn[sel];
    if (w) return perm[1];
    return perm != 2'b00;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    acc_req = 1'b0; acc_addr = '0; acc_write = 1'b0; acc_fetch = 1'b0; acc_priv = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a[4]) m_glb = d[0];
    else if (a[0]) begin
      m_szl[a[3:1]] = d[5:0];  m_srd[a[3:1]] = d[15:8];
      m_pp[a[3:1]]  = d[17:16]; m_up[a[3:1]] = d[19:18];
      m_xn[a[3:1]]  = d[20];    m_en[a[3:1]] = d[31];
    end else m_base[a[3:1]] = {d[31:8], 8'h00};
  endtask

  task automatic set_region(input int i, input logic [31:0] b, input logic [5:0] s, input logic [7:0] sd,
                            input logic [1:0] p, input logic [1:0] u, input logic x, input logic e);
    cfg_write({1'b0, 3'(i), 1'b0}, b);
    cfg_write({1'b0, 3'(i), 1'b1}, {e, 10'h0, x, u, p, sd, 2'b00, s});
  endtask

  // one access; on a denial check capture and terminal behaviour, then reset
  task automatic access(input logic [31:0] a, input logic w, input logic f, input logic p, input string tag);
    logic e;
    e = exp_pass(a, w, f, p);
    @(negedge clk);
    acc_req = 1'b1; acc_addr = a; acc_write = w; acc_fetch = f; acc_priv = p;
    #1;
    check(acc_gnt == e && acc_deny == !e, {tag, " R8 grant"}, {30'h0, acc_gnt, acc_deny}, {30'h0, e, !e});
    @(negedge clk);
    acc_req = 1'b0;
    #1;
    if (e) begin
      check(fault == 1'b0, {tag, " R10 no fault"}, {31'h0, fault}, 32'h0);
    end else begin
      check(fault == 1'b1, {tag, " R10 fault"}, {31'h0, fault}, 32'h1);
      check(fault_addr == a, {tag, " R10 addr"}, fault_addr, a);
      check(fault_status == {1'b1, !f, f}, {tag, " R10 status"}, {29'h0, fault_status}, {29'h0, 1'b1, !f, f});
      // R11 a second request is refused and nothing is overwritten
      acc_req = 1'b1; acc_addr = ~a; acc_fetch = !f; acc_priv = 1'b1; acc_write = 1'b0;
      #1;
      check(acc_deny && !acc_gnt, {tag, " R11 deny"}, {30'h0, acc_gnt, acc_deny}, 32'h1);
      @(negedge clk);
      acc_req = 1'b0;
      repeat (2) @(negedge clk);
      check(fault && fault_addr == a && fault_status == {1'b1, !f, f}, {tag, " R11 held"},
            fault_addr, a);
      do_reset();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    do_reset();
    // R1
    check(fault == 1'b0 && fault_addr == 32'h0 && fault_status == 3'b000, "R1 reset state",
          fault_addr, 32'h0);
    // R8 idle
    #1 check(!acc_gnt && !acc_deny, "R8 idle", {30'h0, acc_gnt, acc_deny}, 32'h0);

    // R1 R6 reset map
    access(32'h1000_0000, 1'b0, 1'b0, 1'b0, "R1 R6 user read ro region");
    access(32'h280C_0000, 1'b0, 1'b0, 1'b0, "R1 read inside rw region");
    access(32'h2810_0000, 1'b0, 1'b0, 1'b0, "R5 R10 read past rw region");
    access(32'h1000_0000, 1'b1, 1'b0, 1'b1, "R6 write to read-only");
    access(32'h1400_0000, 1'b0, 1'b0, 1'b1, "R6 priv read");
    access(32'h1400_0000, 1'b0, 1'b0, 1'b0, "R6 user no access");
    access(32'h1404_0000, 1'b0, 1'b0, 1'b1, "R3 just past 256KB");
    access(32'h4000_1000, 1'b1, 1'b0, 1'b0, "R6 user write rw");
    // R7
    access(32'h4000_0000, 1'b0, 1'b1, 1'b1, "R7 fetch execute-never");
    access(32'h1000_0000, 1'b1, 1'b1, 1'b0, "R7 fetch ignores write flag");
    access(32'h0800_0000, 1'b0, 1'b1, 1'b1, "R7 fetch background no read");

    // R4 subregion 3 of region 3 off
    set_region(3, 32'h2800_0000, 6'd20, 8'h08, 2'b10, 2'b10, 1'b0, 1'b1);
    access(32'h2804_0000, 1'b0, 1'b0, 1'b0, "R4 subregion on");
    access(32'h2806_0000, 1'b0, 1'b0, 1'b0, "R4 subregion off");
    // R5 region 6 over region 4
    set_region(6, 32'h4000_0000, 6'd12, 8'h00, 2'b00, 2'b00, 1'b0, 1'b1);
    access(32'h4000_1000, 1'b0, 1'b0, 1'b1, "R5 past higher region");
    access(32'h4000_0800, 1'b0, 1'b0, 1'b1, "R5 higher index wins");
    // R3 small size clamps to 256 bytes, base low bits ignored
    set_region(7, 32'h5000_0080, 6'd4, 8'h00, 2'b01, 2'b01, 1'b0, 1'b1);
    access(32'h5000_00F0, 1'b0, 1'b0, 1'b0, "R3 clamp inside");
    access(32'h5000_0010, 1'b0, 1'b0, 1'b0, "R3 aligned base");
    access(32'h5000_0100, 1'b0, 1'b0, 1'b0, "R3 clamp outside");
    // R9 R2 global enable
    cfg_write(5'b10000, 32'h0);
    access(32'h1000_0000, 1'b1, 1'b0, 1'b1, "R9 disabled write");
    access(32'h2810_0000, 1'b0, 1'b1, 1'b0, "R9 disabled fetch");
    cfg_write(5'b10000, 32'h1);
    access(32'h2810_0000, 1'b0, 1'b0, 1'b0, "R2 re-enabled");

    // random epochs
    for (int ep = 0; ep < 60; ep++) begin
      int nw;
      do_reset();
      nw = int'($urandom_range(0, 3));
      for (int k = 0; k < nw; k++) begin
        logic [31:0] rb;
        logic [7:0]  sd;
        rb = $urandom();
        sd = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom());
        set_region(int'($urandom_range(0, 7)), rb, 6'($urandom_range(4, 34)), sd,
                   2'($urandom()), 2'($urandom()), 1'($urandom()), ($urandom_range(0, 3) != 0));
      end
      if ($urandom_range(0, 9) == 0) cfg_write(5'b10000, 32'h0);
      for (int k = 0; k < 30; k++) begin
        int r;
        int eff;
        logic [63:0] sz, lo, off;
        logic [31:0] a;
        r   = int'($urandom_range(0, 7));
        eff = (m_szl[r] < 8) ? 8 : ((m_szl[r] >= 32) ? 32 : int'(m_szl[r]));
        sz  = 64'h1 << eff;
        lo  = {32'h0, m_base[r]} & ~(sz - 64'h1);
        off = {32'h0, $urandom()} % (sz * 2);
        a   = ($urandom_range(0, 4) == 0) ? $urandom() : 32'(lo + off);
        access(a, 1'($urandom()), ($urandom_range(0, 3) == 0), 1'($urandom()), "R4 R5 R6 random");
        if (!fault && m_glb && k > 0 && !exp_pass(a, 1'b0, 1'b0, 1'b0)) break;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule